// File: doc/BRIEF.md
# Double-Buffered Address Region Security Filter

This block guards one system port of a memory controller. Every access that arrives on the port carries an address, a flag that says whether it is secure or non-secure, a requester ID and a read/write direction. The block answers each access with a permit or deny verdict one clock later. A denied access can be reported in one of three ways: silently, as a bus error, or as a bus error together with an interrupt pulse.

Software describes up to eight address windows, numbered 0 to 7, through a simple word-wide register port. Each window has a base, a top, a two-bit secure permission, an enable, and a read bit and a write bit for each of 16 non-secure requester IDs. Register writes go only into a shadow copy of this configuration. A flush command copies the whole shadow set into the active set in a single clock, and only the active set judges traffic. Software confirms that a flush has happened by reading back the attribute words, because those reads return active values. Window 0 is the background window: it is always enabled and it catches every address that no other enabled window claims.

Top module: `region_guard`

## Requirements
- R1: After reset, the active attribute word of window 0 reads 0x00000001, the action word reads 0, and a secure read is denied with no error and no interrupt.
- R2: A write to a window register changes only the shadow copy. Checking and attribute read-back are unchanged until a flush.
- R3: Writing a value with bit 0 set to the flush word (offset 0x008) copies every shadow window into the active set at that clock edge. The flush word always reads 0.
- R4: An access presented in the same cycle as the flush write is judged against the configuration that was active before the flush.
- R5: Window words sit at 0x054 + 0x20·n + 4·k, with k=0 base bits [31:12], k=1 base bits [42:32], k=2 top bits [31:12], k=3 top bits [42:32], k=4 attributes and k=5 ID rights. Base bits [11:0] read as zero and top bits [11:0] read as ones. An address matches a window when base ≤ address ≤ top at 4 KB page granularity.
- R6: The enable bit (attribute bit 0) of window 0 cannot be cleared. Writing 0 to it still reads back as 1 after a flush.
- R7: When several enabled windows match an address, the highest-numbered window decides.
- R8: A secure access is permitted by the attribute bit 31 for writes and by bit 30 for reads.
- R9: A non-secure access with ID i is permitted by bit 16+i of the ID-rights word for writes and by bit i for reads.
- R10: The action word (offset 0x050) selects the deny report. 0 gives no error and no interrupt, 1 gives an error, and 2 gives an error plus an interrupt.
- R11: resp_valid follows acc_valid by exactly one cycle, and a permitted access never raises an error or an interrupt.
- R12: A window with enable 0 never decides an access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| acc_valid | input | 1 | Access to check is present |
| acc_addr | input | 43 | Access address |
| acc_nonsec | input | 1 | 1 = non-secure access |
| acc_id | input | 4 | Non-secure requester ID |
| acc_write | input | 1 | 1 = write, 0 = read |
| resp_valid | output | 1 | Verdict present |
| resp_permit | output | 1 | Access permitted |
| resp_err | output | 1 | Deny reported as bus error |
| resp_irq | output | 1 | Deny interrupt pulse |

## Verification
A verdict is registered once, so each access is driven on a falling edge and its result is sampled on the next falling edge, after one rising edge. Register read data has the same one-cycle latency, and a write or flush takes effect at the rising edge inside its strobe, so an access in the following cycle already sees the new state. The flush-cycle case drives the flush write and the access on the same falling edge and expects the old verdict. A second access one cycle later must show the new verdict.

// File: rtl/rg_pkg.sv
package rg_pkg;
  localparam int ADDR_W     = 43;
  localparam int PAGE_SHIFT = 12;
  localparam int PAGE_W     = ADDR_W - PAGE_SHIFT;
  localparam int LO_PG_W    = 32 - PAGE_SHIFT;
  localparam int HI_PG_W    = PAGE_W - LO_PG_W;
  localparam int NUM_IDS    = 16;
  localparam int ID_W       = $clog2(NUM_IDS);
  localparam int REG_AW     = 12;
  localparam int ACT_W      = 2;
  localparam int WORDS      = 6;

  localparam int OFF_FLUSH  = 'h008;
  localparam int OFF_ACTION = 'h050;
  localparam int OFF_GROUP0 = 'h054;
  localparam int STRIDE     = 'h020;

  localparam logic [ACT_W-1:0] ACT_SILENT = 2'd0;
  localparam logic [ACT_W-1:0] ACT_ERR    = 2'd1;

  typedef enum logic [2:0] {
    W_BASE_LO = 3'd0,
    W_BASE_HI = 3'd1,
    W_TOP_LO  = 3'd2,
    W_TOP_HI  = 3'd3,
    W_ATTR    = 3'd4,
    W_IDS     = 3'd5
  } word_e;

  typedef struct packed {
    logic [PAGE_W-1:0]  base_pg;
    logic [PAGE_W-1:0]  top_pg;
    logic [1:0]         sec;     // [1] secure write, [0] secure read
    logic               en;
    logic [NUM_IDS-1:0] id_wr;
    logic [NUM_IDS-1:0] id_rd;
  } region_t;

  localparam region_t R0_RESET = '{base_pg: '0, top_pg: '0, sec: 2'b00,
                                   en: 1'b1, id_wr: '0, id_rd: '0};
endpackage

// File: rtl/rg_regfile.sv
module rg_regfile
  import rg_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  localparam int RGN_W = $clog2(NUM_REGIONS)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic                         rd_en,
  input  logic [REG_AW-1:0]            addr,
  input  logic [31:0]                  wdata,
  output logic [31:0]                  rdata,
  output region_t [NUM_REGIONS-1:0]    act,
  output logic [ACT_W-1:0]             action
);
  region_t [NUM_REGIONS-1:0] sh, sh_nxt, act_nxt;
  logic [ACT_W-1:0] action_nxt;
  logic [31:0]      rd_nxt;
  logic             hit_any, flush_wr;
  logic [RGN_W-1:0] hit_rgn;
  word_e            hit_word;

  // address decode of the repeating window groups
  always_comb begin
    hit_any  = 1'b0;
    hit_rgn  = '0;
    hit_word = W_IDS;
    for (int r = 0; r < NUM_REGIONS; r++) begin
      for (int k = 0; k < WORDS; k++) begin
        if (addr == REG_AW'(OFF_GROUP0 + r * STRIDE + 4 * k)) begin
          hit_any  = 1'b1;
          hit_rgn  = RGN_W'(r);
          hit_word = word_e'(3'(k));
        end
      end
    end
  end

  assign flush_wr = wr_en && (addr == REG_AW'(OFF_FLUSH)) && wdata[0];

  // next state
  always_comb begin
    sh_nxt     = sh;
    act_nxt    = act;
    action_nxt = action;
    if (flush_wr) act_nxt = sh;
    if (wr_en && addr == REG_AW'(OFF_ACTION)) action_nxt = wdata[ACT_W-1:0];
    if (wr_en && hit_any) begin
      case (hit_word)
        W_BASE_LO: sh_nxt[hit_rgn].base_pg[LO_PG_W-1:0]      = wdata[31:PAGE_SHIFT];
        W_BASE_HI: sh_nxt[hit_rgn].base_pg[PAGE_W-1:LO_PG_W] = wdata[HI_PG_W-1:0];
        W_TOP_LO:  sh_nxt[hit_rgn].top_pg[LO_PG_W-1:0]       = wdata[31:PAGE_SHIFT];
        W_TOP_HI:  sh_nxt[hit_rgn].top_pg[PAGE_W-1:LO_PG_W]  = wdata[HI_PG_W-1:0];
        W_ATTR: begin
          sh_nxt[hit_rgn].sec = wdata[31:30];
          sh_nxt[hit_rgn].en  = wdata[0] | (hit_rgn == '0);
        end
        W_IDS: begin
          sh_nxt[hit_rgn].id_wr = wdata[31:16];
          sh_nxt[hit_rgn].id_rd = wdata[15:0];
        end
        default: ;
      endcase
    end
  end

  // read mux: attributes come from the active set, the rest from shadow
  always_comb begin
    rd_nxt = '0;
    if (addr == REG_AW'(OFF_ACTION)) begin
      rd_nxt = 32'(action);
    end else if (hit_any) begin
      case (hit_word)
        W_BASE_LO: rd_nxt = {sh[hit_rgn].base_pg[LO_PG_W-1:0], {PAGE_SHIFT{1'b0}}};
        W_BASE_HI: rd_nxt = 32'(sh[hit_rgn].base_pg[PAGE_W-1:LO_PG_W]);
        W_TOP_LO:  rd_nxt = {sh[hit_rgn].top_pg[LO_PG_W-1:0], {PAGE_SHIFT{1'b1}}};
        W_TOP_HI:  rd_nxt = 32'(sh[hit_rgn].top_pg[PAGE_W-1:LO_PG_W]);
        W_ATTR:    rd_nxt = {act[hit_rgn].sec, 29'b0, act[hit_rgn].en};
        W_IDS:     rd_nxt = {sh[hit_rgn].id_wr, sh[hit_rgn].id_rd};
        default:   rd_nxt = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NUM_REGIONS; r++) begin
        sh[r]  <= (r == 0) ? R0_RESET : '0;
        act[r] <= (r == 0) ? R0_RESET : '0;
      end
      action <= '0;
      rdata  <= '0;
    end else begin
      if (wr_en) begin
        sh     <= sh_nxt;
        act    <= act_nxt;
        action <= action_nxt;
      end
      if (rd_en) rdata <= rd_nxt;
    end
  end

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_chk
    AST_FLUSH_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      flush_wr |=> (act[g] == $past(sh[g]))) else $error("flush copy"); // R3
    AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !flush_wr |=> $stable(act[g])) else $error("active changed"); // R2
  end
  AST_R0_ALWAYS_ON: assert property (@(posedge clk) disable iff (!rst_n)
    act[0].en && sh[0].en) else $error("window 0 disabled"); // R6
endmodule

// File: rtl/rg_lookup.sv
module rg_lookup
  import rg_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  localparam int RGN_W = $clog2(NUM_REGIONS)
) (
  input  region_t [NUM_REGIONS-1:0] cfg,
  input  logic [PAGE_W-1:0]         page,
  output logic [RGN_W-1:0]          win_idx,
  output region_t                   win
);
  logic [NUM_REGIONS-1:0] hit;

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_cmp
    if (g == 0) begin : g_bg
      assign hit[g] = 1'b1;
    end else begin : g_win
      assign hit[g] = cfg[g].en && (page >= cfg[g].base_pg) && (page <= cfg[g].top_pg);
    end
  end

  // highest-numbered hit wins
  always_comb begin
    win_idx = '0;
    for (int r = 1; r < NUM_REGIONS; r++) begin
      if (hit[r]) win_idx = RGN_W'(r);
    end
  end

  assign win = cfg[win_idx];
endmodule

// File: rtl/region_guard.sv
module region_guard
  import rg_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  localparam int RGN_W = $clog2(NUM_REGIONS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_nonsec,
  input  logic [ID_W-1:0]   acc_id,
  input  logic              acc_write,
  output logic              resp_valid,
  output logic              resp_permit,
  output logic              resp_err,
  output logic              resp_irq
);
  logic [1:0] rst_sync;
  logic       rst_q;
  region_t [NUM_REGIONS-1:0] act;
  logic [ACT_W-1:0] action;
  logic [RGN_W-1:0] win_idx;
  region_t          win;
  logic ok, valid_nxt, permit_nxt, err_nxt, irq_nxt;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  rg_regfile #(.NUM_REGIONS(NUM_REGIONS)) i_regs (
    .clk(clk), .rst_n(rst_q), .wr_en(reg_wr), .rd_en(reg_rd), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .act(act), .action(action)
  );

  rg_lookup #(.NUM_REGIONS(NUM_REGIONS)) i_look (
    .cfg(act), .page(acc_addr[ADDR_W-1:PAGE_SHIFT]), .win_idx(win_idx), .win(win)
  );

  always_comb begin
    if (acc_nonsec) ok = acc_write ? win.id_wr[acc_id] : win.id_rd[acc_id];
    else            ok = acc_write ? win.sec[1] : win.sec[0];
    valid_nxt  = acc_valid;
    permit_nxt = acc_valid && ok;
    err_nxt    = acc_valid && !ok && (action != ACT_SILENT);
    irq_nxt    = acc_valid && !ok && (action != ACT_SILENT) && (action != ACT_ERR);
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      resp_valid  <= 1'b0;
      resp_permit <= 1'b0;
      resp_err    <= 1'b0;
      resp_irq    <= 1'b0;
    end else begin
      resp_valid  <= valid_nxt;
      resp_permit <= permit_nxt;
      resp_err    <= err_nxt;
      resp_irq    <= irq_nxt;
    end
  end

  AST_RESP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_q)
    acc_valid |=> resp_valid) else $error("missing verdict"); // R11
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_q)
    !acc_valid |=> !resp_valid) else $error("spurious verdict"); // R11
  AST_PERMIT_CLEAN: assert property (@(posedge clk) disable iff (!rst_q)
    resp_permit |-> (resp_valid && !resp_err && !resp_irq)) else $error("permit flagged"); // R11
  AST_IRQ_HAS_ERR: assert property (@(posedge clk) disable iff (!rst_q)
    resp_irq |-> resp_err) else $error("irq without error"); // R10
  AST_WIN_ENABLED: assert property (@(posedge clk) disable iff (!rst_q)
    acc_valid |-> act[win_idx].en) else $error("disabled window decided"); // R12
endmodule

// File: tb/test_region_guard.sv
module test_region_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        acc_valid = 1'b0, acc_nonsec = 1'b0, acc_write = 1'b0;
  logic [42:0] acc_addr = '0;
  logic [3:0]  acc_id = '0;
  logic        resp_valid, resp_permit, resp_err, resp_irq;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  localparam logic [11:0] A_FLUSH = 12'h008, A_ACTION = 12'h050;
  // verdict encoding {valid, permit, err, irq}
  localparam logic [3:0] V_OK = 4'b1100, V_SIL = 4'b1000, V_ERR = 4'b1010, V_IRQ = 4'b1011;

  always #2.5 clk = ~clk;

  region_guard i_region_guard (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_valid(acc_valid),
    .acc_addr(acc_addr), .acc_nonsec(acc_nonsec), .acc_id(acc_id),
    .acc_write(acc_write), .resp_valid(resp_valid), .resp_permit(resp_permit),
    .resp_err(resp_err), .resp_irq(resp_irq)
  );

  function automatic logic [11:0] wa(input int r, input int k);
    return 12'(32'h054 + r * 32'h20 + k * 4);
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    check(tag, reg_rdata, exp);
  endtask

  task automatic acc_chk(input string tag, input logic [42:0] a, input logic ns,
                         input logic [3:0] id, input logic w, input logic [3:0] exp);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_nonsec = ns; acc_id = id; acc_write = w;
    @(negedge clk);
    acc_valid = 1'b0;
    check(tag, {28'b0, resp_valid, resp_permit, resp_err, resp_irq}, {28'b0, exp});
  endtask

  task automatic t_reset;
    check("R1 no verdict in reset", {31'b0, resp_valid}, 32'd0);
    rd_chk("R1 window0 attr", wa(0, 4), 32'h0000_0001);
    rd_chk("R1 action", A_ACTION, 32'h0);
    acc_chk("R1 secure read denied", 43'h1000, 1'b0, 4'd0, 1'b0, V_SIL);
  endtask

  task automatic t_shadow;
    wr(wa(0, 4), 32'hC000_0001);
    acc_chk("R2 shadow not active", 43'h1000, 1'b0, 4'd0, 1'b0, V_SIL);
    rd_chk("R2 attr still old", wa(0, 4), 32'h0000_0001);
    wr(A_FLUSH, 32'h1);
    rd_chk("R3 attr after flush", wa(0, 4), 32'hC000_0001);
    acc_chk("R3 secure read permitted", 43'h1000, 1'b0, 4'd0, 1'b0, V_OK);
    rd_chk("R3 flush reads 0", A_FLUSH, 32'h0);
  endtask

  task automatic t_r0_enable;
    wr(wa(0, 4), 32'h8000_0000);
    wr(A_FLUSH, 32'h1);
    rd_chk("R6 enable kept", wa(0, 4), 32'h8000_0001);
    acc_chk("R8 secure write ok", 43'h1000, 1'b0, 4'd0, 1'b1, V_OK);
    acc_chk("R8 secure read denied", 43'h1000, 1'b0, 4'd0, 1'b0, V_SIL);
  endtask

  task automatic t_ids;
    wr(wa(0, 5), (32'h1 << 21) | (32'h1 << 3));
    wr(A_FLUSH, 32'h1);
    acc_chk("R9 ns read id3 ok", 43'h1000, 1'b1, 4'd3, 1'b0, V_OK);
    acc_chk("R9 ns read id5 denied", 43'h1000, 1'b1, 4'd5, 1'b0, V_SIL);
    acc_chk("R9 ns write id5 ok", 43'h1000, 1'b1, 4'd5, 1'b1, V_OK);
    acc_chk("R9 ns write id3 denied", 43'h1000, 1'b1, 4'd3, 1'b1, V_SIL);
  endtask

  task automatic t_regions;
    wr(wa(2, 0), 32'h0000_2123); wr(wa(2, 1), 32'h0);
    wr(wa(2, 2), 32'h0000_3000); wr(wa(2, 3), 32'h0);
    wr(wa(2, 4), 32'h4000_0001);
    wr(wa(5, 0), 32'h0000_3000); wr(wa(5, 2), 32'h0000_3FFF);
    wr(wa(5, 4), 32'h8000_0001);
    wr(wa(3, 1), 32'h1); wr(wa(3, 3), 32'h1); wr(wa(3, 2), 32'h0000_0FFF);
    wr(wa(3, 4), 32'hC000_0001);
    wr(wa(4, 2), 32'hFFFF_FFFF); wr(wa(4, 4), 32'hC000_0000);
    wr(A_FLUSH, 32'h1);
    rd_chk("R5 base low bits zero", wa(2, 0), 32'h0000_2000);
    rd_chk("R5 top low bits ones", wa(2, 2), 32'h0000_3FFF);
    acc_chk("R5 base page matches", 43'h2000, 1'b0, 4'd0, 1'b0, V_OK);
    acc_chk("R5 below top end", 43'h2FFF, 1'b0, 4'd0, 1'b0, V_OK);
    acc_chk("R7 higher window read denied", 43'h3000, 1'b0, 4'd0, 1'b0, V_SIL);
    acc_chk("R7 higher window write ok", 43'h3FFF, 1'b0, 4'd0, 1'b1, V_OK);
    acc_chk("R12 disabled window ignored", 43'h4000, 1'b0, 4'd0, 1'b0, V_SIL);
    acc_chk("R5 high word window", 43'h1_0000_0800, 1'b0, 4'd0, 1'b0, V_OK);
    acc_chk("R5 past high top", 43'h1_0000_1000, 1'b0, 4'd0, 1'b0, V_SIL);
  endtask

  task automatic t_actions;
    wr(A_ACTION, 32'h1);
    rd_chk("R10 action readback", A_ACTION, 32'h1);
    acc_chk("R10 deny as error", 43'h4000, 1'b0, 4'd0, 1'b0, V_ERR);
    wr(A_ACTION, 32'h2);
    acc_chk("R10 deny with irq", 43'h4000, 1'b0, 4'd0, 1'b0, V_IRQ);
    acc_chk("R11 permit clean", 43'h4000, 1'b0, 4'd0, 1'b1, V_OK);
    wr(A_ACTION, 32'h0);
    acc_chk("R10 silent again", 43'h4000, 1'b0, 4'd0, 1'b0, V_SIL);
  endtask

  task automatic t_flush_cycle;
    wr(wa(0, 4), 32'h4000_0001);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = A_FLUSH; reg_wdata = 32'h1;
    acc_valid = 1'b1; acc_addr = 43'h4000; acc_nonsec = 1'b0; acc_write = 1'b0;
    @(negedge clk);
    reg_wr = 1'b0; acc_valid = 1'b0;
    check("R4 flush-cycle access uses old", {28'b0, resp_valid, resp_permit, resp_err, resp_irq},
          {28'b0, V_SIL});
    acc_chk("R4 next access uses new", 43'h4000, 1'b0, 4'd0, 1'b0, V_OK);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset_pre: begin
      check("R1 valid low while reset", {31'b0, resp_valid}, 32'd0);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_shadow();
    t_r0_enable();
    t_ids();
    t_regions();
    t_actions();
    t_flush_cycle();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule